// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block is a small non-blocking time-slot interchange. Each frame has `NCH` slots. In every slot the block takes one byte from each of `NS` parallel input streams and writes those bytes into a two-bank data store. The bank being written alternates from one frame to the next. In the same beat the block builds one output byte for each output stream. It does so by looking up a per-channel connection entry, which picks one of four things: a byte from any earlier input slot of any stream, a literal byte supplied by the host, all ones, or no drive at all.

Input and output use valid/ready. One accepted input beat produces exactly one output beat one cycle later. While the output beat waits for `out_ready`, `in_ready` stays low, so back-pressure on the output stalls the input without losing or skipping a slot. A plain register port lets the host write and read connection entries and read back received bytes.

Each connection entry also picks a delay mode. Constant delay keeps every byte of a frame together: all of them appear one frame later. Variable delay sends a byte in the current frame whenever its input slot has completed early enough, which gives lower latency.

Top module: `tsi_switch`

## Requirements
- R1: An output stream `o` in slot `s` can carry the byte received on any input stream and channel. The source is entry field bits [6:5] for the stream and bits [4:0] for the channel, and one source may feed several outputs in the same frame.
- R2: Connection entry `o*NCH+s` is written with `host_we` while `host_addr[8]`=0, at index `host_addr[6:0]` = {stream[1:0], slot[4:0]}. Bits [11:0] are stored and a read returns them with bits [15:12] as 0. The data path uses a written entry from the next accepted beat onward.
- R3: When entry bit 8 (message) is 1 and bit 10 is 0, the output byte is entry bits [7:0].
- R4: When entry bit 10 (force) is 1, the output byte is 8'hFF whatever bits 8 and [7:0] hold.
- R5: When entry bit 11 (drive) is 0, `out_oe` for that stream is 0 and its byte is 8'h00, whatever the other bits hold.
- R6: When bit 9 (constant) is 1 in switched mode, the byte sent is the one received in the previous frame at the source position.
- R7: When bit 9 is 0 in switched mode, the byte comes from the current frame if source channel + 2 <= output slot. Otherwise it comes from the previous frame.
- R8: With `host_re` and `host_addr[8]`=1, the read returns the stored input byte at bank `host_addr[7]`, stream `host_addr[6:5]` and channel `host_addr[4:0]`. Frame F is stored in bank F mod 2. `host_rdata`/`host_rvalid` appear one cycle after `host_re`, and host writes to this region are ignored.
- R9: After reset every entry reads 0, so all outputs are undriven. Both banks hold 0, and the slot count and bank start at 0.
- R10: One output beat follows one cycle after each accepted input beat. A beat held with `out_ready` low keeps `out_data`/`out_oe` stable, and `in_ready` is low while it waits.
- R11: `out_slot` gives the slot of the beat. The slot count wraps after `NCH` accepted beats, and at that point the write bank swaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input slot beat valid |
| in_ready | output | 1 | Block can accept an input beat |
| in_data | input | NS*8 | One byte per input stream, stream 0 in bits [7:0] |
| out_valid | output | 1 | Output slot beat valid |
| out_ready | input | 1 | Consumer accepts the output beat |
| out_data | output | NS*8 | One byte per output stream, stream 0 in bits [7:0] |
| out_oe | output | NS | Per-stream output drive enable |
| out_slot | output | log2(NCH) | Slot index of the output beat |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_addr | input | 2+log2(NS)+log2(NCH) | Host address; top bit selects the data store |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| host_rvalid | output | 1 | Host read data valid |

## Verification
The hardest case to reach is the variable-delay boundary, where the source channel lies exactly one or two slots before the output slot. At that point the bank choice flips between the frame being written and the previous one. Outputs also have to be checked across the bank swap at the frame boundary. The stimulus fills the connection memory at random, so sources land on every distance from the output slot, and it feeds fresh random bytes every frame, so the two banks always differ. Directed entries then pin the exact distances 1 and 2, slot 0 and the last slot, and the force-over-message and undriven-over-everything priorities. Random output stalls check that held beats stay stable.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned HOST_W    = 16;
  localparam int unsigned ENTRY_W   = 12;
  localparam int unsigned MSG_BIT   = 8;
  localparam int unsigned CONST_BIT = 9;
  localparam int unsigned FORCE_BIT = 10;
  localparam int unsigned DRIVE_BIT = 11;
  localparam int unsigned MIN_GAP   = 2;

  typedef enum logic [1:0] {
    SRC_HIZ,
    SRC_ONES,
    SRC_HOST,
    SRC_SWITCH
  } src_kind_e;
endpackage

// File: rtl/tsi_data_mem.sv
module tsi_data_mem
  import tsi_pkg::*;
#(
  parameter int NS  = 4,
  parameter int NCH = 32,
  parameter int NRD = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    wr_bank,
  input  logic [$clog2(NCH)-1:0]  wr_slot,
  input  logic [NS*BYTE_W-1:0]    wr_data,
  input  logic [NRD*(1+$clog2(NS)+$clog2(NCH))-1:0] rd_addr,
  output logic [NRD*BYTE_W-1:0]   rd_data
);
  localparam int SW    = $clog2(NS);
  localparam int CW    = $clog2(NCH);
  localparam int AW    = 1 + SW + CW;
  localparam int DEPTH = 2 * NS * NCH;

  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      for (int s = 0; s < NS; s++)
        mem[{wr_bank, SW'(s), wr_slot}] <= wr_data[s*BYTE_W +: BYTE_W];
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_data[r*BYTE_W +: BYTE_W] = mem[rd_addr[r*AW +: AW]];
  end
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
  import tsi_pkg::*;
#(
  parameter int NS  = 4,
  parameter int NCH = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [$clog2(NS)+$clog2(NCH)-1:0]  wr_idx,
  input  logic [ENTRY_W-1:0]                 wr_entry,
  input  logic [$clog2(NCH)-1:0]             slot,
  output logic [NS*ENTRY_W-1:0]              rd_entries,
  input  logic [$clog2(NS)+$clog2(NCH)-1:0]  hrd_idx,
  output logic [ENTRY_W-1:0]                 hrd_entry
);
  localparam int SW    = $clog2(NS);
  localparam int CW    = $clog2(NCH);
  localparam int DEPTH = NS * NCH;

  logic [ENTRY_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_entry;
    end
  end

  for (genvar o = 0; o < NS; o++) begin : g_port
    assign rd_entries[o*ENTRY_W +: ENTRY_W] = mem[{SW'(o), slot}];
  end

  assign hrd_entry = mem[hrd_idx];

  AST_ENTRY_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_idx)] == $past(wr_entry)); // R2
endmodule

// File: rtl/tsi_out_sel.sv
module tsi_out_sel
  import tsi_pkg::*;
#(
  parameter int NS  = 4,
  parameter int NCH = 32
) (
  input  logic [ENTRY_W-1:0]                   entry,
  input  logic [$clog2(NCH)-1:0]               slot,
  input  logic                                 wr_bank,
  output logic [$clog2(NS)+$clog2(NCH):0]      dm_addr,
  input  logic [BYTE_W-1:0]                    dm_byte,
  output logic [BYTE_W-1:0]                    byte_out,
  output logic                                 drive
);
  localparam int SW   = $clog2(NS);
  localparam int CW   = $clog2(NCH);
  localparam int IDXW = SW + CW;

  logic [CW-1:0] src_ch;
  logic [SW-1:0] src_st;
  logic [CW:0]   due;
  logic          use_cur;
  src_kind_e     kind;

  assign src_ch  = entry[CW-1:0];
  assign src_st  = entry[IDXW-1:CW];
  assign due     = {1'b0, src_ch} + (CW+1)'(MIN_GAP);
  assign use_cur = !entry[CONST_BIT] && (due <= {1'b0, slot});
  assign dm_addr = {use_cur ? wr_bank : ~wr_bank, src_st, src_ch};

  always_comb begin
    if (!entry[DRIVE_BIT])     kind = SRC_HIZ;
    else if (entry[FORCE_BIT]) kind = SRC_ONES;
    else if (entry[MSG_BIT])   kind = SRC_HOST;
    else                       kind = SRC_SWITCH;
  end

  always_comb begin
    drive = 1'b1;
    unique case (kind)
      SRC_HIZ:    begin byte_out = '0; drive = 1'b0; end
      SRC_ONES:   byte_out = '1;
      SRC_HOST:   byte_out = entry[BYTE_W-1:0];
      SRC_SWITCH: byte_out = dm_byte;
      default:    byte_out = '0;
    endcase
  end
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int NS  = 4,
  parameter int NCH = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                in_valid,
  output logic                                in_ready,
  input  logic [NS*8-1:0]                     in_data,
  output logic                                out_valid,
  input  logic                                out_ready,
  output logic [NS*8-1:0]                     out_data,
  output logic [NS-1:0]                       out_oe,
  output logic [$clog2(NCH)-1:0]              out_slot,
  input  logic                                host_we,
  input  logic                                host_re,
  input  logic [$clog2(NS)+$clog2(NCH)+1:0]   host_addr,
  input  logic [15:0]                         host_wdata,
  output logic [15:0]                         host_rdata,
  output logic                                host_rvalid
);
  localparam int SW   = $clog2(NS);
  localparam int CW   = $clog2(NCH);
  localparam int IDXW = SW + CW;
  localparam int AW   = 1 + IDXW;
  localparam int NRD  = NS + 1;

  logic [CW-1:0]          slot_q;
  logic                   bank_q;
  logic                   fire;
  logic [NS*ENTRY_W-1:0]  entries;
  logic [ENTRY_W-1:0]     cm_host;
  logic [NRD*AW-1:0]      dm_raddr;
  logic [NRD*BYTE_W-1:0]  dm_rdata;
  logic [NS*BYTE_W-1:0]   sel_bytes;
  logic [NS-1:0]          sel_drive;
  logic                   cm_we;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;
  assign cm_we    = host_we && !host_addr[AW];

  tsi_conn_mem #(.NS(NS), .NCH(NCH)) u_cm (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cm_we),
    .wr_idx     (host_addr[IDXW-1:0]),
    .wr_entry   (host_wdata[ENTRY_W-1:0]),
    .slot       (slot_q),
    .rd_entries (entries),
    .hrd_idx    (host_addr[IDXW-1:0]),
    .hrd_entry  (cm_host)
  );

  tsi_data_mem #(.NS(NS), .NCH(NCH), .NRD(NRD)) u_dm (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (fire),
    .wr_bank (bank_q),
    .wr_slot (slot_q),
    .wr_data (in_data),
    .rd_addr (dm_raddr),
    .rd_data (dm_rdata)
  );

  assign dm_raddr[NS*AW +: AW] = host_addr[AW-1:0];

  for (genvar o = 0; o < NS; o++) begin : g_out
    tsi_out_sel #(.NS(NS), .NCH(NCH)) u_sel (
      .entry    (entries[o*ENTRY_W +: ENTRY_W]),
      .slot     (slot_q),
      .wr_bank  (bank_q),
      .dm_addr  (dm_raddr[o*AW +: AW]),
      .dm_byte  (dm_rdata[o*BYTE_W +: BYTE_W]),
      .byte_out (sel_bytes[o*BYTE_W +: BYTE_W]),
      .drive    (sel_drive[o])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q    <= '0;
      bank_q    <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_oe    <= '0;
      out_slot  <= '0;
    end else begin
      if (fire) begin
        out_data <= sel_bytes;
        out_oe   <= sel_drive;
        out_slot <= slot_q;
        if (slot_q == CW'(NCH-1)) begin
          slot_q <= '0;
          bank_q <= ~bank_q;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end
      out_valid <= fire || (out_valid && !out_ready);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= host_re;
      if (host_re)
        host_rdata <= host_addr[AW]
          ? {{(HOST_W-BYTE_W){1'b0}}, dm_rdata[NS*BYTE_W +: BYTE_W]}
          : {{(HOST_W-ENTRY_W){1'b0}}, cm_host};
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_oe)); // R10
  AST_BEAT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R10
  AST_SLOT_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_slot == $past(slot_q)); // R11
  AST_BANK_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && slot_q == CW'(NCH-1) |=> bank_q != $past(bank_q)); // R11
  AST_READ_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    host_re |=> host_rvalid); // R8
endmodule

// File: tb/sim_tsi_switch.sv
module sim_tsi_switch;
  localparam int NS = 4, NCH = 32;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready, out_valid, host_rvalid;
  logic [31:0] out_data;
  logic [3:0]  out_oe;
  logic [4:0]  out_slot;
  logic        host_we = 1'b0, host_re = 1'b0;
  logic [8:0]  host_addr = '0;
  logic [15:0] host_wdata = '0, host_rdata;

  int total = 0, fails = 0, slot_m = 0, fnum = 0;
  bit done = 0;
  logic [15:0] cm [NS*NCH];
  logic [7:0]  cur [NS][NCH];
  logic [7:0]  prev [NS][NCH];

  tsi_switch #(.NS(NS), .NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_oe(out_oe),
    .out_slot(out_slot), .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid));

  always #5 clk = ~clk;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] model_out(logic [15:0] e, int s);
    int st, ch;
    if (!e[11]) return 9'h000;
    if (e[10])  return 9'h1FF;
    if (e[8])   return {1'b1, e[7:0]};
    st = int'(e[6:5]); ch = int'(e[4:0]);
    if (!e[9] && ch + 2 <= s) return {1'b1, cur[st][ch]};
    return {1'b1, prev[st][ch]};
  endfunction

  function automatic string req_of(logic [15:0] e);
    if (!e[11]) return "R5";
    if (e[10])  return "R4";
    if (e[8])   return "R3";
    if (e[9])   return "R1 R6";
    return "R1 R7";
  endfunction

  task automatic host_write(logic [8:0] a, logic [15:0] d);
    @(negedge clk); host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 1'b0;
    if (!a[8]) cm[a[6:0]] = d & 16'h0FFF;
  endtask

  task automatic host_read(logic [8:0] a, output logic [15:0] d);
    @(negedge clk); host_re = 1'b1; host_addr = a;
    @(negedge clk); host_re = 1'b0;
    check("R8", "rvalid", 32'(host_rvalid), 32'd1);
    d = host_rdata;
  endtask

  task automatic do_slot(bit after_reset);
    logic [31:0] din = $urandom;
    logic [8:0]  exp [NS];
    logic [31:0] held;
    int stall;
    for (int o = 0; o < NS; o++) exp[o] = model_out(cm[o*NCH+slot_m], slot_m);
    @(negedge clk);
    check("R10", "in_ready idle", 32'(in_ready), 32'd1);
    in_valid = 1'b1; in_data = din;
    @(negedge clk); in_valid = 1'b0;
    check("R10", "out_valid", 32'(out_valid), 32'd1);
    check("R11", "out_slot", 32'(out_slot), 32'(slot_m));
    for (int o = 0; o < NS; o++) begin
      string r = after_reset ? "R9" : req_of(cm[o*NCH+slot_m]);
      check(r, $sformatf("oe s%0d o%0d", slot_m, o), 32'(out_oe[o]), 32'(exp[o][8]));
      check(r, $sformatf("data s%0d o%0d", slot_m, o), 32'(out_data[o*8 +: 8]), 32'(exp[o][7:0]));
    end
    held = out_data;
    stall = $urandom_range(0, 2);
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      check("R10", "stall in_ready", 32'(in_ready), 32'd0);
      check("R10", "stall hold", out_data, held);
    end
    out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
    check("R10", "drained", 32'(out_valid), 32'd0);
    for (int s = 0; s < NS; s++) cur[s][slot_m] = din[s*8 +: 8];
    slot_m++;
    if (slot_m == NCH) begin
      slot_m = 0; fnum++;
      for (int s = 0; s < NS; s++) for (int c = 0; c < NCH; c++) prev[s][c] = cur[s][c];
    end
  endtask

  task automatic run_frames(int n, bit after_reset);
    for (int f = 0; f < n * NCH; f++) do_slot(after_reset);
  endtask

  task automatic check_dm(int n);
    logic [15:0] d;
    logic [8:0]  a;
    for (int k = 0; k < n; k++) begin
      int st = $urandom_range(0, NS-1), ch = $urandom_range(0, NCH-1);
      a = {1'b1, 1'(fnum - 1), 2'(st), 5'(ch)};
      host_read(a, d);
      check("R8", "dm read", 32'(d), 32'(prev[st][ch]));
      host_write(a, 16'h00A5);
      host_read(a, d);
      check("R8", "dm write ignored", 32'(d), 32'(prev[st][ch]));
    end
  endtask

  initial begin
    logic [15:0] d;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < NS*NCH; i++) cm[i] = '0;
    for (int s = 0; s < NS; s++) for (int c = 0; c < NCH; c++) begin cur[s][c] = '0; prev[s][c] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    check("R9", "out_valid reset", 32'(out_valid), 32'd0);
    check("R10", "in_ready reset", 32'(in_ready), 32'd1);
    host_read(9'd0, d);   check("R9", "cm[0] reset", 32'(d), 32'd0);
    host_read(9'd127, d); check("R9", "cm[127] reset", 32'(d), 32'd0);
    run_frames(1, 1'b1);
    check_dm(3);
    for (int i = 0; i < NS*NCH; i++) begin
      logic [15:0] w = 16'($urandom);
      w[11] = ($urandom_range(0, 7) != 0);
      w[10] = ($urandom_range(0, 7) == 0);
      w[8]  = ($urandom_range(0, 3) == 0);
      host_write(9'(i), w);
    end
    host_read(9'd77, d);
    check("R2", "cm readback", 32'(d), 32'(cm[77]));
    run_frames(6, 1'b0);
    check_dm(4);
    // directed corner entries (variable-delay distances 2 and 1, priorities, slot edges)
    host_write(9'(0*NCH+5),  16'h0800 | (2 << 5) | 3);
    host_write(9'(1*NCH+5),  16'h0800 | (2 << 5) | 4);
    host_write(9'(2*NCH+5),  16'h0F5A);
    host_write(9'(3*NCH+5),  16'h0733);
    host_write(9'(0*NCH+31), 16'h0800 | (3 << 5) | 29);
    host_write(9'(1*NCH+0),  16'h0800 | (1 << 5) | 0);
    host_write(9'(2*NCH+31), 16'h0A00 | (0 << 5) | 31);
    host_write(9'(3*NCH+4),  16'h0900 | 8'hC3);
    host_write(9'(3*NCH+6),  16'hF800 | 8'h21);
    host_read(9'(3*NCH+6), d);
    check("R2", "upper bits dropped", 32'(d), 32'h0821);
    run_frames(2, 1'b0);
    check_dm(2);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule